// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the timing skeleton of a video raster from a pixel clock. A horizontal counter runs through the pixels of a line. A vertical counter advances twice per line, so a field is measured in half-lines. From these two running positions the block derives a rectangular active-video flag and several independent horizontal/vertical sync pairs. Each pair has its own edge positions, which are programmed through a word-addressed register bus.

The block runs in one of two modes. As a master it free-runs. As a slave it also snaps its counters back to the start of the raster whenever an external sync input is high. A restart register reloads the line and field lengths and returns the raster to its origin, so a new geometry always begins from a clean frame. A two-bit interrupt unit records when the raster enters the top field or the bottom field. A mask, altered through separate set and clear registers, decides which of those status bits drive the interrupt level.

Top module: `raster_sync_gen`

## Requirements
- R1: After reset the pixel position is 0, the line number is 1 and the field is top. Address 1 (line length) reads DEF_LINE_LEN (16). Address 2 (field length in half-lines) reads DEF_FIELD_HL (8). Address 0 (mode), address 8 (status) and the mask all read 0, and irq is low.
- R2: The pixel position counts 0 to L-1 and returns to 0, where L is the line length in force.
- R3: The half-line count advances when the pixel position is floor(L/2)-1 and when it is L-1. It wraps to 0 after F-1, where F is the field length in force, and each wrap toggles between the top and bottom field. The line number is floor(half-line/2)+1.
- R4: A write to address 1 or address 2 is readable at once but does not change the counting. A write of bit 0 = 1 to address 3 loads the written lengths and sends the counters to pixel 0, line 1, top field on the next clock.
- R5: With address 0 bit 0 = 1 (slave), ext_sync high at a clock edge returns the counters to pixel 0, line 1, top field. With bit 0 = 0 (master), ext_sync has no effect.
- R6: hsync[k] is high while the pixel position p satisfies s <= p < e. Here s is bits 15:0 and e is bits 31:16 of address 16+8k. When s > e the span wraps (p >= s or p < e). When s = e the output never goes high.
- R7: vsync[k] compares the raster key (line<<16 | pixel) against a rise key and a fall key. The rise key is (line reg bits 15:0)<<16 | (offset reg bits 15:0). The fall key uses bits 31:16 of both. The top field uses line reg 16+8k+1 and offset reg 16+8k+3; the bottom field uses 16+8k+2 and 16+8k+4. The output is high on the half-open span from rise to fall, wrapping when rise > fall.
- R8: active is high when the line is within [start line, stop line] and the pixel is within [start pixel, stop pixel], both inclusive. Each word packs the line in bits 31:16 and the pixel in bits 15:0. The top field uses start at address 4 and stop at 5; the bottom field uses 6 and 7.
- R9: Status (address 8) bit 1 sets when the raster wraps into the top field, and bit 0 sets when it wraps into the bottom field. A restart or realignment sets neither bit. Writing ones to address 9 clears those bits. A field event in the same cycle as a clear leaves its bit set.
- R10: Writing ones to address 11 sets mask bits and writing ones to address 10 clears them. Both addresses read the mask. irq is high exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ext_sync | input | 1 | External realignment input used in slave mode |
| hsync | output | NUM_OUT | Horizontal sync outputs |
| vsync | output | NUM_OUT | Vertical sync outputs |
| active | output | 1 | Active-video window flag |
| irq | output | 1 | Masked interrupt level |

## Verification
Two collisions are provoked on purpose. The first is a field wrap that lands in the same cycle as a status-clear write. The bench watches its reference raster and issues the clear so that it takes effect on exactly the edge where the field changes. It then reads address 8 and expects the new field's bit still set while the other bit is gone. The second is a restart write issued while pending lengths differ from the active ones. The bench confirms that the old lengths govern every sync, window and interrupt output until that edge, and the new ones govern them after it.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
    // Width of one packed half of a 32-bit edge or window word
    localparam int HW = 16;

    // Register word addresses
    localparam int A_MODE      = 0;
    localparam int A_LINE      = 1;
    localparam int A_FIELD     = 2;
    localparam int A_RESTART   = 3;
    localparam int A_WIN       = 4;   // 4..7: top start, top stop, bottom start, bottom stop
    localparam int A_STAT      = 8;
    localparam int A_STAT_CLR  = 9;
    localparam int A_MASK_CLR  = 10;
    localparam int A_MASK_SET  = 11;
    localparam int A_SYNC_BASE = 16;
    localparam int SYNC_STRIDE = 8;

    // Per-output edge registers
    localparam int EDGE_REGS   = 5;
    localparam int E_HS        = 0;
    localparam int E_VL_TOP    = 1;
    localparam int E_VL_BOT    = 2;
    localparam int E_VO_TOP    = 3;
    localparam int E_VO_BOT    = 4;

    // Half-open span test with wrap-around; an empty span when s == e
    function automatic logic in_span(input logic [2*HW-1:0] cur,
                                     input logic [2*HW-1:0] s,
                                     input logic [2*HW-1:0] e);
        if (s <= e) return (cur >= s) && (cur < e);
        else        return (cur >= s) || (cur < e);
    endfunction
endpackage

// File: rtl/rsg_raster_cnt.sv
module rsg_raster_cnt
    import rsg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] line_len,
    input  logic [HW-1:0] field_hl,
    input  logic          restart,
    input  logic          align,
    output logic [HW-1:0] hcnt,
    output logic [HW-1:0] line_no,
    output logic          bot_field,
    output logic          evt_top,
    output logic          evt_bot
);
    typedef struct packed {
        logic [HW-1:0] hcnt;
        logic [HW-1:0] hl;
        logic          bot;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [HW-1:0] mid;
    logic          adv, wrap, home;

    always_comb begin
        mid   = line_len >> 1;
        adv   = (cnt_q.hcnt == line_len - 1'b1) ||
                ((mid != '0) && (cnt_q.hcnt == mid - 1'b1));
        wrap  = adv && (cnt_q.hl >= field_hl - 1'b1);
        home  = restart || align;
        cnt_d = cnt_q;
        if (home) begin
            cnt_d = '0;
        end else begin
            cnt_d.hcnt = (cnt_q.hcnt >= line_len - 1'b1) ? '0 : cnt_q.hcnt + 1'b1;
            if (adv) begin
                cnt_d.hl  = wrap ? '0 : cnt_q.hl + 1'b1;
                cnt_d.bot = wrap ? ~cnt_q.bot : cnt_q.bot;
            end
        end
        evt_top = wrap && !home &&  cnt_q.bot;
        evt_bot = wrap && !home && !cnt_q.bot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hcnt      = cnt_q.hcnt;
    assign line_no   = (cnt_q.hl >> 1) + 1'b1;
    assign bot_field = cnt_q.bot;
endmodule

// File: rtl/rsg_sync_out.sv
module rsg_sync_out
    import rsg_pkg::*;
(
    input  logic [HW-1:0]                 hcnt,
    input  logic [HW-1:0]                 line_no,
    input  logic                          bot_field,
    input  logic [EDGE_REGS-1:0][2*HW-1:0] edges,
    output logic                          hs,
    output logic                          vs
);
    logic [2*HW-1:0] vl, vo, pos;

    always_comb begin
        pos = {line_no, hcnt};
        vl  = bot_field ? edges[E_VL_BOT] : edges[E_VL_TOP];
        vo  = bot_field ? edges[E_VO_BOT] : edges[E_VO_TOP];
        hs  = in_span({{HW{1'b0}}, hcnt},
                      {{HW{1'b0}}, edges[E_HS][HW-1:0]},
                      {{HW{1'b0}}, edges[E_HS][2*HW-1:HW]});
        vs  = in_span(pos, {vl[HW-1:0], vo[HW-1:0]},
                           {vl[2*HW-1:HW], vo[2*HW-1:HW]});
    end
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import rsg_pkg::*;
#(
    parameter int NUM_OUT      = 4,
    parameter int ADDR_W       = 6,   // needs A_SYNC_BASE + SYNC_STRIDE*NUM_OUT <= 2**ADDR_W
    parameter int DEF_LINE_LEN = 16,
    parameter int DEF_FIELD_HL = 8
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               ext_sync,
    output logic [NUM_OUT-1:0] hsync,
    output logic [NUM_OUT-1:0] vsync,
    output logic               active,
    output logic               irq
);
    typedef struct packed {
        logic                                      mode;
        logic [HW-1:0]                             len_pend;
        logic [HW-1:0]                             fhl_pend;
        logic [HW-1:0]                             len_act;
        logic [HW-1:0]                             fhl_act;
        logic [3:0][2*HW-1:0]                      win;
        logic [NUM_OUT-1:0][EDGE_REGS-1:0][2*HW-1:0] edges;
        logic [1:0]                                stat;
        logic [1:0]                                mask;
    } regs_t;

    regs_t regs_d, regs_q;

    logic          restart, align, stat_clr_we;
    logic [HW-1:0] hcnt, line_no;
    logic          bot_field, evt_top, evt_bot;
    logic [2*HW-1:0] ws, we;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
        return a == ADDR_W'(target);
    endfunction

    always_comb begin
        restart     = bus_we && hit(bus_addr, A_RESTART) && bus_wdata[0];
        align       = regs_q.mode && ext_sync;
        stat_clr_we = bus_we && hit(bus_addr, A_STAT_CLR);
        regs_d      = regs_q;
        if (bus_we) begin
            if (hit(bus_addr, A_MODE))     regs_d.mode     = bus_wdata[0];
            if (hit(bus_addr, A_LINE))     regs_d.len_pend = bus_wdata[HW-1:0];
            if (hit(bus_addr, A_FIELD))    regs_d.fhl_pend = bus_wdata[HW-1:0];
            if (hit(bus_addr, A_MASK_CLR)) regs_d.mask     = regs_q.mask & ~bus_wdata[1:0];
            if (hit(bus_addr, A_MASK_SET)) regs_d.mask     = regs_q.mask |  bus_wdata[1:0];
            for (int w = 0; w < 4; w++)
                if (hit(bus_addr, A_WIN + w)) regs_d.win[w] = bus_wdata;
            for (int k = 0; k < NUM_OUT; k++)
                for (int j = 0; j < EDGE_REGS; j++)
                    if (hit(bus_addr, A_SYNC_BASE + k*SYNC_STRIDE + j))
                        regs_d.edges[k][j] = bus_wdata;
        end
        if (restart) begin
            regs_d.len_act = regs_q.len_pend;
            regs_d.fhl_act = regs_q.fhl_pend;
        end
        // a field event outranks a same-cycle clear
        regs_d.stat = (regs_q.stat & ~(stat_clr_we ? bus_wdata[1:0] : 2'b00))
                    | {evt_top, evt_bot};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q          <= '0;
            regs_q.len_pend <= HW'(DEF_LINE_LEN);
            regs_q.fhl_pend <= HW'(DEF_FIELD_HL);
            regs_q.len_act  <= HW'(DEF_LINE_LEN);
            regs_q.fhl_act  <= HW'(DEF_FIELD_HL);
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, A_MODE))  bus_rdata = {31'b0, regs_q.mode};
        if (hit(bus_addr, A_LINE))  bus_rdata = {{(32-HW){1'b0}}, regs_q.len_pend};
        if (hit(bus_addr, A_FIELD)) bus_rdata = {{(32-HW){1'b0}}, regs_q.fhl_pend};
        if (hit(bus_addr, A_STAT))  bus_rdata = {30'b0, regs_q.stat};
        if (hit(bus_addr, A_MASK_CLR) || hit(bus_addr, A_MASK_SET))
            bus_rdata = {30'b0, regs_q.mask};
        for (int w = 0; w < 4; w++)
            if (hit(bus_addr, A_WIN + w)) bus_rdata = regs_q.win[w];
        for (int k = 0; k < NUM_OUT; k++)
            for (int j = 0; j < EDGE_REGS; j++)
                if (hit(bus_addr, A_SYNC_BASE + k*SYNC_STRIDE + j))
                    bus_rdata = regs_q.edges[k][j];
    end

    rsg_raster_cnt u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_len  (regs_q.len_act),
        .field_hl  (regs_q.fhl_act),
        .restart   (restart),
        .align     (align),
        .hcnt      (hcnt),
        .line_no   (line_no),
        .bot_field (bot_field),
        .evt_top   (evt_top),
        .evt_bot   (evt_bot)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        rsg_sync_out u_out (
            .hcnt      (hcnt),
            .line_no   (line_no),
            .bot_field (bot_field),
            .edges     (regs_q.edges[k]),
            .hs        (hsync[k]),
            .vs        (vsync[k])
        );
    end

    always_comb begin
        ws     = bot_field ? regs_q.win[2] : regs_q.win[0];
        we     = bot_field ? regs_q.win[3] : regs_q.win[1];
        active = (line_no >= ws[2*HW-1:HW]) && (line_no <= we[2*HW-1:HW]) &&
                 (hcnt    >= ws[HW-1:0])    && (hcnt    <= we[HW-1:0]);
    end

    assign irq = |(regs_q.stat & regs_q.mask);
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker
    import rsg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          restart,
    input logic          align,
    input logic [HW-1:0] hcnt,
    input logic [HW-1:0] line_no,
    input logic          bot_field,
    input logic [HW-1:0] len_act,
    input logic          evt_top,
    input logic          evt_bot,
    input logic [1:0]    stat,
    input logic          clr_we,
    input logic [1:0]    clr_bits
);
    // R2: pixel position stays below the active line length
    a_r2_hcnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (len_act != '0) |-> (hcnt < len_act));

    // R2: ordinary counting steps by one
    a_r2_hcnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !align && ({1'b0, hcnt} + 1'b1 < {1'b0, len_act}))
        |=> (hcnt == $past(hcnt) + 1'b1));

    // R3: a field event toggles the field
    a_r3_field_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_top || evt_bot) |=> (bot_field != $past(bot_field)));

    // R4: restart returns to the origin
    a_r4_restart_home: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (hcnt == '0 && line_no == 1 && !bot_field));

    // R4: active length only moves on restart
    a_r4_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(len_act));

    // R5: slave realignment returns to the origin
    a_r5_align_home: assert property (@(posedge clk) disable iff (!rst_n)
        align |=> (hcnt == '0 && line_no == 1 && !bot_field));

    // R9: events set status even under a clear
    a_r9_top_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_top |=> stat[1]);
    a_r9_bot_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_bot |=> stat[0]);

    // R9: a clear without a competing event empties the bit
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_bits[0] && !evt_bot) |=> !stat[0]);
endmodule

bind raster_sync_gen rsg_checker u_rsg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .align     (align),
    .hcnt      (hcnt),
    .line_no   (line_no),
    .bot_field (bot_field),
    .len_act   (regs_q.len_act),
    .evt_top   (evt_top),
    .evt_bot   (evt_bot),
    .stat      (regs_q.stat),
    .clr_we    (stat_clr_we),
    .clr_bits  (bus_wdata[1:0])
);

// File: tb/raster_sync_gen_bench.sv
module raster_sync_gen_bench;
    localparam int NO = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          ext_sync = 1'b0;
    logic [NO-1:0] hsync, vsync;
    logic          active, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit run = 0;
    string phase = "R1";

    always #10 clk = ~clk;   // 50 MHz

    raster_sync_gen u_raster_sync_gen (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_sync(ext_sync),
        .hsync(hsync), .vsync(vsync), .active(active), .irq(irq)
    );

    // ---------------- reference model ----------------
    int unsigned m_h, m_hl, m_L, m_F, m_Lp, m_Fp, m_mode, m_stat, m_mask;
    bit          m_bot;
    bit [31:0]   m_win [4];
    bit [31:0]   m_edge [NO][5];

    task automatic model_reset();
        m_h = 0; m_hl = 0; m_bot = 0; m_L = 16; m_F = 8; m_Lp = 16; m_Fp = 8;
        m_mode = 0; m_stat = 0; m_mask = 0;
        for (int i = 0; i < 4; i++) m_win[i] = 0;
        for (int k = 0; k < NO; k++) for (int j = 0; j < 5; j++) m_edge[k][j] = 0;
    endtask

    initial model_reset();

    function automatic bit span(longint c, longint s, longint e);
        if (s <= e) return (c >= s) && (c < e);
        return (c >= s) || (c < e);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            bit restart_w, align_w, adv, wrap;
            int unsigned half, setb, a;
            restart_w = bus_we && bus_addr == 3 && bus_wdata[0];
            align_w   = (m_mode == 1) && ext_sync;
            half = m_L / 2;
            adv  = (m_h == m_L - 1) || (half >= 1 && m_h == half - 1);
            wrap = adv && (m_hl >= m_F - 1);
            setb = 0;
            if (wrap && !restart_w && !align_w) setb = m_bot ? 2 : 1;
            a = bus_addr;
            if (bus_we) begin
                if (a == 0) m_mode = bus_wdata[0];
                if (a == 1) m_Lp = bus_wdata[15:0];
                if (a == 2) m_Fp = bus_wdata[15:0];
                if (a >= 4 && a <= 7) m_win[a-4] = bus_wdata;
                if (a == 9) m_stat = m_stat & ~int'(bus_wdata[1:0]);
                if (a == 10) m_mask = m_mask & ~int'(bus_wdata[1:0]);
                if (a == 11) m_mask = m_mask | bus_wdata[1:0];
                if (a >= 16 && (a - 16) / 8 < NO && (a - 16) % 8 < 5)
                    m_edge[(a-16)/8][(a-16)%8] = bus_wdata;
            end
            m_stat = m_stat | setb;
            if (restart_w || align_w) begin
                if (restart_w) begin
                    // lengths as they stood before this edge's writes
                    m_L = (bus_we && a == 1) ? m_L : m_Lp;
                    m_F = (bus_we && a == 2) ? m_F : m_Fp;
                end
                m_h = 0; m_hl = 0; m_bot = 0;
            end else begin
                m_h = (m_h >= m_L - 1) ? 0 : m_h + 1;
                if (adv) begin
                    if (wrap) begin m_hl = 0; m_bot = !m_bot; end
                    else m_hl = m_hl + 1;
                end
            end
        end
    end

    // ---------------- checks ----------------
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && run) begin
            logic [NO-1:0] ehs, evs;
            longint line, pos;
            bit [31:0] ws, we, vl, vo;
            bit ea;
            line = m_hl / 2 + 1;
            pos  = line * 65536 + m_h;
            for (int k = 0; k < NO; k++) begin
                ehs[k] = span(m_h, m_edge[k][0][15:0], m_edge[k][0][31:16]);
                vl = m_bot ? m_edge[k][2] : m_edge[k][1];
                vo = m_bot ? m_edge[k][4] : m_edge[k][3];
                evs[k] = span(pos, longint'(vl[15:0]) * 65536 + vo[15:0],
                                   longint'(vl[31:16]) * 65536 + vo[31:16]);
            end
            ws = m_bot ? m_win[2] : m_win[0];
            we = m_bot ? m_win[3] : m_win[1];
            ea = line >= ws[31:16] && line <= we[31:16] && m_h >= ws[15:0] && m_h <= we[15:0];
            check({phase, "/R6"}, "hsync",  32'(hsync),  32'(ehs));
            check({phase, "/R7"}, "vsync",  32'(vsync),  32'(evs));
            check({phase, "/R8"}, "active", 32'(active), 32'(ea));
            check({phase, "/R10"}, "irq",   32'(irq),    32'((m_stat & m_mask) != 0));
        end
    end

    // caller stands at a negedge; returns at the next negedge
    task automatic wr(input int a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_check(input string req, input int a, input logic [31:0] exp);
        bus_addr = AW'(a);
        #1;
        check(req, "rdata", bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;
        @(negedge clk);
        // R1: reset values
        phase = "R1";
        rd_check("R1", 1, 32'd16);
        rd_check("R1", 2, 32'd8);
        rd_check("R1", 0, 32'd0);
        rd_check("R1", 8, 32'd0);
        rd_check("R1", 10, 32'd0);
        check("R1", "irq", 32'(irq), 32'd0);
        idle(20);

        // R4: program while old lengths still run
        phase = "R4";
        wr(1, 20); wr(2, 12);
        wr(16, {16'd4, 16'd0});  wr(17, {16'd2, 16'd1});  wr(18, {16'd3, 16'd2});
        wr(19, 0);               wr(20, {16'd5, 16'd5});
        wr(24, {16'd3, 16'd18}); wr(25, {16'd1, 16'd6});  wr(26, {16'd1, 16'd6});
        wr(27, {16'd2, 16'd10}); wr(28, {16'd2, 16'd10});
        wr(32, {16'd7, 16'd7});  wr(33, {16'd4, 16'd2});  wr(35, {16'd15, 16'd3});
        wr(40, {16'd19, 16'd1}); wr(41, {16'd6, 16'd5});  wr(42, {16'd5, 16'd3});
        wr(43, {16'd0, 16'd19}); wr(44, {16'd7, 16'd7});
        wr(4, {16'd2, 16'd3});   wr(5, {16'd5, 16'd16});
        wr(6, {16'd3, 16'd0});   wr(7, {16'd4, 16'd19});
        rd_check("R4", 1, 32'd20);
        rd_check("R4", 2, 32'd12);
        rd_check("R6", 24, {16'd3, 16'd18});
        idle(40);

        // R2/R3: restart and count with new geometry
        phase = "R2R3";
        wr(3, 1);
        idle(130);
        // one field wrap (top to bottom) after 120 cycles
        rd_check("R9", 8, 32'd1);
        check("R10", "irq masked", 32'(irq), 32'd0);

        // R10: mask set and clear
        phase = "R10";
        wr(11, 3);
        rd_check("R10", 11, 32'd3);
        check("R10", "irq", 32'(irq), 32'd1);
        wr(10, 1);
        rd_check("R10", 10, 32'd2);
        check("R10", "irq", 32'(irq), 32'd0);
        wr(11, 1);
        wr(9, 3);
        rd_check("R9", 8, 32'd0);
        idle(150);

        // R9: clear lands in the same cycle as a field wrap
        phase = "R9";
        wr(9, 3);
        while (!(m_h == 19 && m_hl == 11)) @(negedge clk);
        begin
            bit to_top;
            to_top = m_bot;
            wr(9, 3);
            rd_check("R9", 8, to_top ? 32'd2 : 32'd1);
        end
        idle(60);

        // R5: slave realignment, then master ignores ext_sync
        phase = "R5";
        wr(0, 1);
        idle(37);
        ext_sync = 1'b1; @(negedge clk); ext_sync = 1'b0;
        idle(70);
        wr(0, 0);
        idle(23);
        ext_sync = 1'b1; @(negedge clk); ext_sync = 1'b0;
        idle(70);

        // R2/R3 with odd line length
        phase = "R3odd";
        wr(1, 7); wr(2, 6); wr(3, 1);
        idle(120);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule